// File: doc/BRIEF.md
# Registered Arithmetic/Logic Unit with Operand Routing

This block is a 16-bit three-bus arithmetic/logic unit. Two operand ports feed it and one result port leaves it. Each of the three ports has its own register, and a per-port mode bit either puts that register in the path or bypasses it. This lets the surrounding logic pick any pipeline depth from zero to two stages. Two routing fields choose the value that drives each side of the ALU: operand A, operand B, the held result, or zero. Selecting the held result closes an accumulator loop inside the block.

A 3-bit function code selects one of eight operations: clear, two subtractions, addition, three bitwise operations and preset. Arithmetic operations use the incoming carry and report a carry-out. They also report a group propagate and a group generate, so an external look-ahead unit can chain several blocks. An output enable gates the result port. Inside the chip this is modelled as a valid flag plus zeroed data.

A typical use is frequency division. Route the held result to R and a constant step on B to S, and select addition. The result register then advances by the step every clock, and the carry-out pulses once per wrap of the 16-bit sum.

Top module: `pipe_alu`

## Requirements
- R1: The function code selects the result as follows: 000 gives zero, 001 gives S−R, 010 gives R−S, 011 gives R+S, 100 gives R XOR S, 101 gives R OR S, 110 gives R AND S, and 111 gives all ones.
- R2: Subtraction is two's complement. The subtrahend is inverted and `carryIn` supplies the +1, so R−S with `carryIn`=1 is exact. `carryIn` is also added in R+S.
- R3: For codes 001, 010 and 011, the flags are computed on the two adder inputs after any inversion. `carryOut` is the carry out of bit 15. `grpProp` is the AND over all bits of (x OR y). `grpGen` is the carry out of x+y with no carry in. These obey `carryOut` = `grpGen` OR (`grpProp` AND `carryIn`). For all other codes, all three flags are 0.
- R4: `selR` and `selS` each route a source to one side of the ALU: 00 is operand A, 01 is operand B, 10 is the result register, 11 is zero.
- R5: When `regA` is 1, operand A is the value that `opA` held at the previous clock edge; when it is 0, `opA` is used directly. `regB` and `opB` work the same way.
- R6: The result register loads the ALU result and flags on every clock edge. When `regF` is 1, the outputs show that register, one cycle behind the ALU; when it is 0, they show the ALU result combinationally.
- R7: When `outEn` is 0, `resF` is zero and `resValid` is 0. When `outEn` is 1, `resValid` is 1. `outEn` does not affect the flags or any register.
- R8: A synchronous `rst` clears the operand and result registers, including the held flags.
- R9: In accumulator mode (code 011, R = result register, S = B, `regF`=1), the result register advances by B + `carryIn` every clock. With a step of 0x1000, `carryOut` pulses once every 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 16 | Operand A |
| opB | input | 16 | Operand B |
| carryIn | input | 1 | Carry into the arithmetic operations |
| func | input | 3 | Function code |
| selR | input | 2 | Source routed to ALU side R |
| selS | input | 2 | Source routed to ALU side S |
| regA | input | 1 | 1: use registered operand A |
| regB | input | 1 | 1: use registered operand B |
| regF | input | 1 | 1: outputs come from the result register |
| outEn | input | 1 | Result port enable |
| resF | output | 16 | Result, zero while disabled |
| resValid | output | 1 | Result port enabled |
| carryOut | output | 1 | Carry out of the top bit |
| grpProp | output | 1 | Group propagate |
| grpGen | output | 1 | Group generate |

## Verification
The bench builds the block with its defaults: a 16-bit width and 4-bit look-ahead groups. At this size, overflow at bit 15 and carries that cross the group boundaries are both reached by ordinary operand values. So are carry chains that run the full width, such as 0xFFFF+1 and 0x7FFF+1. The 0x1000 accumulator step wraps in 16 clocks, which makes the divided-down carry pulse observable in a short run.

// File: rtl/pipe_alu_pkg.sv
package pipe_alu_pkg;

  localparam int FUNC_W = 3;
  localparam int SEL_W  = 2;
  localparam int NSRC   = 1 << SEL_W;

  typedef enum logic [FUNC_W-1:0] {
    FN_CLEAR  = 3'd0,
    FN_SMR    = 3'd1,
    FN_RMS    = 3'd2,
    FN_ADD    = 3'd3,
    FN_XOR    = 3'd4,
    FN_OR     = 3'd5,
    FN_AND    = 3'd6,
    FN_PRESET = 3'd7
  } aluFunc_e;

  typedef enum logic [2:0] {
    LOP_ZERO,
    LOP_XOR,
    LOP_OR,
    LOP_AND,
    LOP_ONES
  } logicOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic            arith;   // adder result and flags are used
    logic            invR;    // complement side R before the adder
    logic            invS;    // complement side S before the adder
    logic            cinEn;   // carryIn takes part
    logicOp_e        lop;     // non-arithmetic result select
    logic [NSRC-1:0] rPick;   // one-hot source for side R
    logic [NSRC-1:0] sPick;   // one-hot source for side S
    logic            holdA;
    logic            holdB;
    logic            holdF;
  } aluStrobes_t;

endpackage

// File: rtl/pipe_alu_ctrl.sv
module pipe_alu_ctrl
  import pipe_alu_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic [SEL_W-1:0]  selR,
  input  logic [SEL_W-1:0]  selS,
  input  logic              regA,
  input  logic              regB,
  input  logic              regF,
  output aluStrobes_t       strobe
);

  always_comb begin
    strobe       = '0;
    strobe.lop   = LOP_ZERO;
    strobe.rPick = NSRC'(1) << selR;
    strobe.sPick = NSRC'(1) << selS;
    strobe.holdA = regA;
    strobe.holdB = regB;
    strobe.holdF = regF;
    case (aluFunc_e'(func))
      FN_CLEAR:  strobe.lop = LOP_ZERO;
      FN_SMR: begin
        strobe.arith = 1'b1;
        strobe.invR  = 1'b1;
        strobe.cinEn = 1'b1;
      end
      FN_RMS: begin
        strobe.arith = 1'b1;
        strobe.invS  = 1'b1;
        strobe.cinEn = 1'b1;
      end
      FN_ADD: begin
        strobe.arith = 1'b1;
        strobe.cinEn = 1'b1;
      end
      FN_XOR:    strobe.lop = LOP_XOR;
      FN_OR:     strobe.lop = LOP_OR;
      FN_AND:    strobe.lop = LOP_AND;
      FN_PRESET: strobe.lop = LOP_ONES;
      default:   strobe.lop = LOP_ZERO;
    endcase
  end

endmodule

// File: rtl/pipe_alu_datapath.sv
module pipe_alu_datapath
  import pipe_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  aluStrobes_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             outEn,
  output logic [WIDTH-1:0] resF,
  output logic             resValid,
  output logic             carryOut,
  output logic             grpProp,
  output logic             grpGen
);

  localparam int NGROUP = WIDTH / GROUP_W;

  logic [WIDTH-1:0] aReg, bReg, fReg;
  logic             coReg, pReg, gReg;
  logic [WIDTH-1:0] aIn, bIn;
  logic [WIDTH-1:0] srcBus [NSRC];
  logic [WIDTH-1:0] rOp, sOp, xOp, yOp;
  logic [WIDTH-1:0] bitP, bitG, bitX, sumBits;
  logic [NGROUP-1:0] groupP, groupG;
  logic [NGROUP:0]   cGrp;
  logic              cinEff, pAll, gAll;
  logic [WIDTH-1:0]  aluRes;
  logic              aluCo, aluP, aluG;

  // Operand bypass selection
  assign aIn = strobe.holdA ? aReg : opA;
  assign bIn = strobe.holdB ? bReg : opB;

  assign srcBus[0] = aIn;
  assign srcBus[1] = bIn;
  assign srcBus[2] = fReg;
  assign srcBus[3] = '0;

  // One-hot AND-OR routing onto both ALU sides
  always_comb begin
    rOp = '0;
    sOp = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (strobe.rPick[i]) rOp = rOp | srcBus[i];
      if (strobe.sPick[i]) sOp = sOp | srcBus[i];
    end
  end

  assign xOp    = strobe.invR ? ~rOp : rOp;
  assign yOp    = strobe.invS ? ~sOp : sOp;
  assign bitP   = xOp | yOp;
  assign bitG   = xOp & yOp;
  assign bitX   = xOp ^ yOp;
  assign cinEff = strobe.cinEn & carryIn;

  // Per-group look-ahead terms and in-group ripple
  for (genvar k = 0; k < NGROUP; k++) begin : g_grp
    logic [GROUP_W:0] cLocal;
    logic [GROUP_W:0] gLocal;
    always_comb begin
      cLocal[0] = cGrp[k];
      gLocal[0] = 1'b0;
      for (int j = 0; j < GROUP_W; j++) begin
        cLocal[j+1] = bitG[k*GROUP_W+j] | (bitP[k*GROUP_W+j] & cLocal[j]);
        gLocal[j+1] = bitG[k*GROUP_W+j] | (bitP[k*GROUP_W+j] & gLocal[j]);
      end
    end
    assign groupP[k] = &bitP[k*GROUP_W +: GROUP_W];
    assign groupG[k] = gLocal[GROUP_W];
    assign sumBits[k*GROUP_W +: GROUP_W] =
      bitX[k*GROUP_W +: GROUP_W] ^ cLocal[GROUP_W-1:0];
  end

  // Carries between groups and whole-word propagate/generate
  always_comb begin
    cGrp[0] = cinEff;
    gAll    = 1'b0;
    for (int k = 0; k < NGROUP; k++) begin
      cGrp[k+1] = groupG[k] | (groupP[k] & cGrp[k]);
      gAll      = groupG[k] | (groupP[k] & gAll);
    end
    pAll = &groupP;
  end

  // Result selection
  always_comb begin
    aluCo = 1'b0;
    aluP  = 1'b0;
    aluG  = 1'b0;
    if (strobe.arith) begin
      aluRes = sumBits;
      aluCo  = cGrp[NGROUP];
      aluP   = pAll;
      aluG   = gAll;
    end else begin
      case (strobe.lop)
        LOP_XOR:  aluRes = rOp ^ sOp;
        LOP_OR:   aluRes = rOp | sOp;
        LOP_AND:  aluRes = rOp & sOp;
        LOP_ONES: aluRes = '1;
        default:  aluRes = '0;
      endcase
    end
  end

  // Port registers load every edge; the mode bits only choose the tap
  always_ff @(posedge clk) begin
    if (rst) begin
      aReg  <= '0;
      bReg  <= '0;
      fReg  <= '0;
      coReg <= 1'b0;
      pReg  <= 1'b0;
      gReg  <= 1'b0;
    end else begin
      aReg  <= opA;
      bReg  <= opB;
      fReg  <= aluRes;
      coReg <= aluCo;
      pReg  <= aluP;
      gReg  <= aluG;
    end
  end

  logic [WIDTH-1:0] fOut;
  assign fOut     = strobe.holdF ? fReg  : aluRes;
  assign carryOut = strobe.holdF ? coReg : aluCo;
  assign grpProp  = strobe.holdF ? pReg  : aluP;
  assign grpGen   = strobe.holdF ? gReg  : aluG;
  assign resF     = outEn ? fOut : '0;
  assign resValid = outEn;

endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  input  logic [FUNC_W-1:0] func,
  input  logic [SEL_W-1:0]  selR,
  input  logic [SEL_W-1:0]  selS,
  input  logic              regA,
  input  logic              regB,
  input  logic              regF,
  input  logic              outEn,
  output logic [WIDTH-1:0]  resF,
  output logic              resValid,
  output logic              carryOut,
  output logic              grpProp,
  output logic              grpGen
);

  aluStrobes_t strobe;

  pipe_alu_ctrl u_ctrl (
    .func   (func),
    .selR   (selR),
    .selS   (selS),
    .regA   (regA),
    .regB   (regB),
    .regF   (regF),
    .strobe (strobe)
  );

  pipe_alu_datapath #(
    .WIDTH   (WIDTH),
    .GROUP_W (GROUP_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .outEn    (outEn),
    .resF     (resF),
    .resValid (resValid),
    .carryOut (carryOut),
    .grpProp  (grpProp),
    .grpGen   (grpGen)
  );

endmodule

// File: rtl/pipe_alu_checker.sv
module pipe_alu_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [2:0]       func,
  input logic [1:0]       selR,
  input logic [1:0]       selS,
  input logic             regB,
  input logic             regF,
  input logic             outEn,
  input logic [WIDTH-1:0] resF,
  input logic             resValid,
  input logic             carryOut,
  input logic             grpProp,
  input logic             grpGen
);

  logic isArith;
  assign isArith = (func == 3'd1) || (func == 3'd2) || (func == 3'd3);

  assert_port_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !outEn |-> (resF == '0) && !resValid);

  assert_port_valid_R7: assert property (@(posedge clk) disable iff (rst)
    outEn |-> resValid);

  assert_carry_lookahead_R3: assert property (@(posedge clk) disable iff (rst)
    (!regF && isArith) |-> carryOut == (grpGen | (grpProp & carryIn)));

  assert_logic_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (!regF && !isArith) |-> !carryOut && !grpProp && !grpGen);

  assert_clear_preset_R1: assert property (@(posedge clk) disable iff (rst)
    (!regF && outEn && (func == 3'd0 || func == 3'd7)) |->
      resF == ((func == 3'd7) ? {WIDTH{1'b1}} : {WIDTH{1'b0}}));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && regF && outEn) |-> (resF == '0) && !carryOut && !grpProp && !grpGen);

  assert_held_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!regF && outEn) && regF && outEn) |->
      (resF == $past(resF)) && (carryOut == $past(carryOut)));

  assert_accumulate_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func == 3'd3 && selR == 2'd2 && selS == 2'd1 &&
                          !regB && regF && outEn) && regF && outEn) |->
      resF == WIDTH'($past(resF) + $past(opB) + WIDTH'($past(carryIn))));

endmodule

bind pipe_alu pipe_alu_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_pipe_alu.sv
module test_pipe_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] opA, opB;
  logic        carryIn;
  logic [2:0]  func;
  logic [1:0]  selR, selS;
  logic        regA, regB, regF, outEn;
  logic [15:0] resF;
  logic        resValid, carryOut, grpProp, grpGen;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pipe_alu i_pipe_alu (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .carryIn(carryIn),
    .func(func), .selR(selR), .selS(selS), .regA(regA), .regB(regB),
    .regF(regF), .outEn(outEn), .resF(resF), .resValid(resValid),
    .carryOut(carryOut), .grpProp(grpProp), .grpGen(grpGen)
  );

  // {func, selR, selS, carryIn, opA, opB}; sources 0 A, 1 B, 2 F, 3 zero
  localparam logic [39:0] VEC [0:17] = '{
    {3'd3, 2'd0, 2'd1, 1'b0, 16'h1234, 16'h0F0F},
    {3'd3, 2'd0, 2'd1, 1'b1, 16'hFFFF, 16'h0001},
    {3'd2, 2'd0, 2'd1, 1'b1, 16'h0005, 16'h0005},
    {3'd2, 2'd0, 2'd1, 1'b1, 16'h0000, 16'h0001},
    {3'd1, 2'd0, 2'd1, 1'b1, 16'h0003, 16'h0010},
    {3'd4, 2'd0, 2'd1, 1'b0, 16'hF0F0, 16'hFF00},
    {3'd5, 2'd0, 2'd1, 1'b1, 16'h1200, 16'h0034},
    {3'd6, 2'd0, 2'd1, 1'b1, 16'hF0F0, 16'h3C3C},
    {3'd0, 2'd0, 2'd1, 1'b1, 16'hFFFF, 16'hFFFF},
    {3'd7, 2'd3, 2'd3, 1'b1, 16'h0000, 16'h0000},
    {3'd3, 2'd1, 2'd0, 1'b0, 16'h8000, 16'h8000},
    {3'd3, 2'd2, 2'd1, 1'b0, 16'h0000, 16'h0101},
    {3'd3, 2'd2, 2'd2, 1'b0, 16'h5555, 16'h0000},
    {3'd3, 2'd3, 2'd0, 1'b1, 16'h7FFF, 16'h1111},
    {3'd2, 2'd3, 2'd1, 1'b1, 16'h2222, 16'h0001},
    {3'd1, 2'd2, 2'd3, 1'b1, 16'h3333, 16'h4444},
    {3'd3, 2'd0, 2'd3, 1'b0, 16'hA5A5, 16'h0000},
    {3'd4, 2'd1, 2'd2, 1'b0, 16'h0000, 16'h0FF0}
  };

  // Reference state for the three port registers and held flags
  logic [15:0] mA = '0, mB = '0, mF = '0;
  logic        mC = 1'b0, mP = 1'b0, mG = 1'b0;
  int          carrySeen;

  task automatic step(input logic [2:0] f, input logic [1:0] r, input logic [1:0] s,
                      input logic ci, input logic [15:0] a, input logic [15:0] b,
                      input logic ra, input logic rb, input logic rf,
                      input logic oe, input logic rs, input string tag);
    logic [15:0] srcA, srcB, rv, sv, x, y, res, expF;
    logic [16:0] full, noCin;
    logic        co, p, g, eC, eP, eG;
    @(negedge clk);
    rst = rs; opA = a; opB = b; carryIn = ci; func = f; selR = r; selS = s;
    regA = ra; regB = rb; regF = rf; outEn = oe;
    #5;
    srcA = ra ? mA : a;
    srcB = rb ? mB : b;
    case (r) 2'd0: rv = srcA; 2'd1: rv = srcB; 2'd2: rv = mF; default: rv = '0; endcase
    case (s) 2'd0: sv = srcA; 2'd1: sv = srcB; 2'd2: sv = mF; default: sv = '0; endcase
    x = (f == 3'd1) ? ~rv : rv;
    y = (f == 3'd2) ? ~sv : sv;
    co = 1'b0; p = 1'b0; g = 1'b0;
    case (f)
      3'd1, 3'd2, 3'd3: begin
        full  = {1'b0, x} + {1'b0, y} + {16'd0, ci};
        noCin = {1'b0, x} + {1'b0, y};
        res = full[15:0]; co = full[16]; g = noCin[16]; p = &(x | y);
      end
      3'd4: res = rv ^ sv;
      3'd5: res = rv | sv;
      3'd6: res = rv & sv;
      3'd7: res = 16'hFFFF;
      default: res = 16'h0000;
    endcase
    expF = rf ? mF : res;
    eC = rf ? mC : co;
    eP = rf ? mP : p;
    eG = rf ? mG : g;
    if (!oe) expF = '0;
    checks++;
    if ({resF, resValid, carryOut, grpProp, grpGen} !== {expF, oe, eC, eP, eG}) begin
      errors++;
      $display("FAIL %s: got F=%h v=%b c=%b p=%b g=%b, expected F=%h v=%b c=%b p=%b g=%b",
               tag, resF, resValid, carryOut, grpProp, grpGen, expF, oe, eC, eP, eG);
    end
    if (carryOut === 1'b1) carrySeen++;
    if (rs) begin
      mA = '0; mB = '0; mF = '0; mC = 1'b0; mP = 1'b0; mG = 1'b0;
    end else begin
      mA = a; mB = b; mF = res; mC = co; mP = p; mG = g;
    end
  endtask

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; opA = '0; opB = '0; carryIn = 1'b0; func = '0; selR = '0; selS = '0;
    regA = 1'b0; regB = 1'b0; regF = 1'b0; outEn = 1'b1;
    carrySeen = 0;

    // R8: reset clears registers, visible through held result after reset
    step(3'd7, 2'd0, 2'd1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8 prefill");
    step(3'd3, 2'd0, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R8 in reset");
    step(3'd3, 2'd0, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8 cleared");

    // Table walk: flow-through, fully registered, and mixed pipelines
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 18; i++) begin
        logic [39:0] v;
        v = VEC[i];
        step(v[39:37], v[36:35], v[34:33], v[32], v[31:16], v[15:0],
             m != 0, m == 1, m != 0, 1'b1, 1'b0,
             m == 0 ? "R1,R2,R3,R4 flow" : (m == 1 ? "R4,R5,R6 registered" : "R5,R6 mixed"));
      end
    end

    // R2 corner: 0 - 1 with carryIn gives all ones and no carry
    step(3'd2, 2'd0, 2'd1, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 borrow");
    check(resF == 16'hFFFF && carryOut == 1'b0, "R2 zero minus one", resF, 16'hFFFF);
    // R3: all-ones plus one carries through every group
    step(3'd3, 2'd0, 2'd1, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 ripple");
    check(resF == 16'h0000 && carryOut && grpProp && !grpGen, "R3 propagate only",
          {grpProp, grpGen, carryOut}, 3'b101);

    // R7: disabled port zeroes data, flags untouched, registers still load
    step(3'd7, 2'd3, 2'd3, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 disabled");
    step(3'd0, 2'd0, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 held after disable");
    check(resF == 16'hFFFF, "R7 result register kept loading", resF, 16'hFFFF);

    // R9: accumulator divider, step 0x1000, carry visible once per 16 clocks
    step(3'd0, 2'd0, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9 reset");
    carrySeen = 0;
    for (int n = 0; n < 65; n++) begin
      step(3'd3, 2'd2, 2'd1, 1'b0, 16'h0000, 16'h1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 accumulate");
    end
    check(carrySeen == 4, "R9 divided carry count", carrySeen, 4);
    check(resF == 16'h0000, "R9 wrapped phase", resF, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule